// File: doc/BRIEF.md
# Settable BCD Countdown Timer with Final-Minute Warning

This block holds a countdown time as six BCD digits (hours, minutes, seconds). The user sets it with two step keys and two field-select keys, then starts it. While running it loses one second on every 1 Hz tick and borrows downward through the fields. It stops at 00:00:00 rather than wrapping. During the last minute it blinks an active-low warning output at 1 Hz. It also gives a one-cycle pulse on the tick that empties the count. The time-of-day clock, the seven-segment decoding and the key debouncing sit outside this block. The time-of-day clock never sees this block's state, and this block never sees the clock's state.

The block is built around a four-state controller:
- **OFF**: the mode switch is low and the digits are frozen.
- **SET**: adjust. On each repeat tick, a held step key changes the selected field.
- **COUNT**: the count falls once per second tick.
- **HALT**: running, but the count is at zero.

The transitions are:
- **any → OFF**: taken when the mode switch falls.
- **OFF/SET → COUNT**: taken when the run switch is high and the count is non-zero.
- **OFF/SET → HALT**: taken when the run switch is high and the count is zero.
- **COUNT → HALT** (expiry): taken on the tick that moves 00:00:01 to 00:00:00. Expiry wins over every other COUNT exit.
- **COUNT/HALT → SET**: taken when the run switch falls.

Top module: `cdown_timer`

## Requirements
- R1: After reset, `bcd_time` is 24'h000000, `running` is 0, `warn_n` is 1 and `done` is 0.
- R2: While `mode_en` is 0, repeat ticks, second ticks and keys leave `bcd_time` unchanged, and `running` is 0.
- R3: With `mode_en`=1 and `run_sw`=0, each `rep_tick` while a step key is held (active-low) moves one field by one step. The field is chosen by the select keys: `key_n[3]` low alone selects hours, `key_n[2]` low alone selects seconds, and both high selects minutes. Up is `key_n[0]` and down is `key_n[1]`. When both select keys are low, no field changes.
- R4: When both step keys are held, the field steps up.
- R5: In adjust, seconds and minutes wrap 59↔00 and hours wrap 23↔00, with no carry or borrow into another field. Every field always holds a valid BCD value within its limit.
- R6: With `run_sw`=1 and a non-zero count, `running` is 1 and every `sec_tick` lowers the total by exactly one second.
- R7: When counting, seconds at 00 reload to 59 and borrow from minutes. Minutes at 00 reload to 59 and borrow from hours.
- R8: When counting, the count stops at 00:00:00, `running` falls, and further ticks change nothing.
- R9: `done` is high for exactly one cycle, together with `bcd_time`=0, after the tick that takes 00:00:01 to 00:00:00.
- R10: While counting, if hours and minutes are 00 and seconds are non-zero, `warn_n` toggles on each `sec_tick`. Otherwise it returns to 1 the next cycle. It is never 0 unless hours and minutes are 00.
- R11: Starting the run with a count of zero enters HALT without a `done` pulse, and `running` stays 0.
- R12: `sec_tick` has no effect in adjust, and `rep_tick` has no effect while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| rep_tick | input | 1 | One-cycle adjust repeat pulse (8 Hz) |
| mode_en | input | 1 | 1 = countdown mode selected |
| run_sw | input | 1 | 1 = run, 0 = adjust |
| key_n | input | 4 | Active-low keys: [0] up, [1] down, [2] seconds select, [3] hours select |
| bcd_time | output | 24 | {hour tens, hour units, minute tens, minute units, second tens, second units} |
| running | output | 1 | Controller is in COUNT |
| warn_n | output | 1 | Active-low final-minute blink |
| done | output | 1 | One-cycle expiry pulse |

## Verification
A wrong controller state shows up at the ports within one tick. For example, a COUNT that never reaches HALT shows as `running` staying high with `bcd_time` at zero, or as a second `done` cycle. A broken borrow chain shows as a wrong digit on the very tick that crosses 00 seconds or 00 minutes. The vector walk therefore lands on those tick boundaries. A bad wrap constant in a field shows on the first step across 59 or 23. A warning toggle that is out of phase is visible on the first tick of the final minute and on the cycle after expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SET,
        ST_COUNT,
        ST_HALT
    } cdt_state_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
    } bcd2_t;

    function automatic int bcd2_val(bcd2_t v);
        return int'(v.tens) * 10 + int'(v.units);
    endfunction

endpackage

// File: rtl/cdt_field.sv
module cdt_field
    import cdt_pkg::*;
#(
    parameter int LIMIT = 59
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    input  logic  dec,
    output bcd2_t val,
    output logic  zero
);
    localparam logic [DIGIT_W-1:0] LIM_T = DIGIT_W'(LIMIT / 10);
    localparam logic [DIGIT_W-1:0] LIM_U = DIGIT_W'(LIMIT % 10);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (inc) begin
            if (val.tens == LIM_T && val.units == LIM_U) begin
                val <= '0;
            end else if (val.units == 4'd9) begin
                val.units <= 4'd0;
                val.tens  <= val.tens + 4'd1;
            end else begin
                val.units <= val.units + 4'd1;
            end
        end else if (dec) begin
            if (val.tens == 4'd0 && val.units == 4'd0) begin
                val.tens  <= LIM_T;
                val.units <= LIM_U;
            end else if (val.units == 4'd0) begin
                val.units <= 4'd9;
                val.tens  <= val.tens - 4'd1;
            end else begin
                val.units <= val.units - 4'd1;
            end
        end
    end

    assign zero = (val.tens == 4'd0) && (val.units == 4'd0);

    // R5: field stays a legal BCD pair within its limit
    p_field_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (val.units <= 4'd9) && (bcd2_val(val) <= LIMIT));

endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
    import cdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_en,
    input  logic       run_sw,
    input  logic       sec_tick,
    input  logic       is_zero,
    input  logic       last_sec,
    output cdt_state_e state,
    output logic       done
);
    cdt_state_e nxt;
    logic       expire;

    assign expire = (state == ST_COUNT) && sec_tick && last_sec;

    always_comb begin
        nxt = state;
        if (!mode_en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF, ST_SET: begin
                    if (run_sw) nxt = is_zero ? ST_HALT : ST_COUNT;
                    else        nxt = ST_SET;
                end
                ST_COUNT: begin
                    if (expire)       nxt = ST_HALT;
                    else if (!run_sw) nxt = ST_SET;
                    else              nxt = ST_COUNT;
                end
                ST_HALT: begin
                    nxt = run_sw ? ST_HALT : ST_SET;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= expire;
    end

    // R9: expiry pulse lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: COUNT never holds an empty count
    p_count_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> !is_zero);

endmodule

// File: rtl/cdt_warn.sv
module cdt_warn (
    input  logic clk,
    input  logic rst_n,
    input  logic final_min,
    input  logic sec_tick,
    output logic warn_n
);
    always_ff @(posedge clk) begin
        if (!rst_n)          warn_n <= 1'b1;
        else if (!final_min) warn_n <= 1'b1;
        else if (sec_tick)   warn_n <= ~warn_n;
    end
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
    import cdt_pkg::*;
#(
    parameter int SEC_LIMIT = 59,
    parameter int MIN_LIMIT = 59,
    parameter int HR_LIMIT  = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic        rep_tick,
    input  logic        mode_en,
    input  logic        run_sw,
    input  logic [3:0]  key_n,
    output logic [23:0] bcd_time,
    output logic        running,
    output logic        warn_n,
    output logic        done
);
    localparam int NFIELD = 3;

    cdt_state_e         state;
    bcd2_t              fv [NFIELD];
    logic [NFIELD-1:0]  fz;
    logic [NFIELD-1:0]  finc;
    logic [NFIELD-1:0]  fdec;
    logic [NFIELD-1:0]  sel;
    logic               adj_step;
    logic               cnt_step;
    logic               up_key;
    logic               dn_key;
    logic               all_zero;
    logic               last_sec;
    logic               final_min;
    logic [16:0]        tot;

    // field select: index 0 seconds, 1 minutes, 2 hours
    assign sel[0]   =  key_n[3] & ~key_n[2];
    assign sel[1]   =  key_n[3] &  key_n[2];
    assign sel[2]   = ~key_n[3] &  key_n[2];
    assign up_key   = ~key_n[0];
    assign dn_key   =  key_n[0] & ~key_n[1];
    assign adj_step = (state == ST_SET) && rep_tick;
    assign cnt_step = (state == ST_COUNT) && sec_tick;

    assign all_zero  = &fz;
    assign last_sec  = fz[2] && fz[1] && (fv[0].tens == 4'd0) && (fv[0].units == 4'd1);
    assign final_min = (state == ST_COUNT) && fz[2] && fz[1] && !fz[0];

    generate
        for (genvar g = 0; g < NFIELD; g++) begin : g_field
            localparam int LIM = (g == 0) ? SEC_LIMIT : ((g == 1) ? MIN_LIMIT : HR_LIMIT);
            logic borrow_in;
            if (g == 0) begin : g_lsb
                assign borrow_in = cnt_step;
            end else begin : g_upper
                assign borrow_in = cnt_step & (&fz[g-1:0]);
            end
            assign finc[g] = adj_step & sel[g] & up_key;
            assign fdec[g] = (adj_step & sel[g] & dn_key) | borrow_in;

            cdt_field #(.LIMIT(LIM)) i_field (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (finc[g]),
                .dec   (fdec[g]),
                .val   (fv[g]),
                .zero  (fz[g])
            );
        end
    endgenerate

    cdt_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_en  (mode_en),
        .run_sw   (run_sw),
        .sec_tick (sec_tick),
        .is_zero  (all_zero),
        .last_sec (last_sec),
        .state    (state),
        .done     (done)
    );

    cdt_warn i_warn (
        .clk       (clk),
        .rst_n     (rst_n),
        .final_min (final_min),
        .sec_tick  (sec_tick),
        .warn_n    (warn_n)
    );

    assign bcd_time = {fv[2], fv[1], fv[0]};
    assign running  = (state == ST_COUNT);
    assign tot      = 17'(bcd2_val(fv[2]) * 3600 + bcd2_val(fv[1]) * 60 + bcd2_val(fv[0]));

    // R6: each counted tick removes exactly one second
    p_one_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_step |=> (tot == $past(tot) - 17'd1));

    // R8: HALT freezes the digits
    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> $stable(bcd_time));

    // R2: OFF freezes the digits
    p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> $stable(bcd_time));

    // R12: repeat ticks are ignored while counting
    p_rep_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_COUNT) && !sec_tick) |=> $stable(bcd_time));

    // R10: warning only in the final minute
    p_warn_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !warn_n |-> (fz[2] && fz[1]));

endmodule

// File: tb/test_cdown_timer.sv
module test_cdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        rep_tick = 1'b0;
    logic        mode_en = 1'b0;
    logic        run_sw = 1'b0;
    logic [3:0]  key_n = 4'hF;
    logic [23:0] bcd_time;
    logic        running;
    logic        warn_n;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cdown_timer i_cdown_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .rep_tick (rep_tick),
        .mode_en  (mode_en),
        .run_sw   (run_sw),
        .key_n    (key_n),
        .bcd_time (bcd_time),
        .running  (running),
        .warn_n   (warn_n),
        .done     (done)
    );

    // {mode, run, key_n[3:0], n_rep[3:0], n_sec[3:0], expected hhmmss BCD}
    localparam int NVEC = 16;
    localparam logic [37:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 4'b1110, 4'd3, 4'd0, 24'h000300}, // R3 minutes up
        {1'b1, 1'b0, 4'b1101, 4'd5, 4'd0, 24'h005800}, // R3 minutes down through 00
        {1'b1, 1'b0, 4'b0110, 4'd1, 4'd0, 24'h015800}, // R3 hours up
        {1'b1, 1'b0, 4'b0101, 4'd2, 4'd0, 24'h235800}, // R5 hours wrap down
        {1'b1, 1'b0, 4'b0110, 4'd1, 4'd0, 24'h005800}, // R5 hours wrap up
        {1'b1, 1'b0, 4'b1001, 4'd1, 4'd0, 24'h005859}, // R5 seconds wrap down
        {1'b1, 1'b0, 4'b1010, 4'd2, 4'd0, 24'h005801}, // R5 seconds wrap up
        {1'b1, 1'b0, 4'b1100, 4'd1, 4'd0, 24'h005901}, // R4 up wins
        {1'b1, 1'b0, 4'b0010, 4'd2, 4'd0, 24'h005901}, // R3 both selects held
        {1'b1, 1'b0, 4'b1110, 4'd1, 4'd0, 24'h000001}, // R5 minutes wrap, no carry
        {1'b1, 1'b0, 4'b1111, 4'd0, 4'd3, 24'h000001}, // R12 second tick in adjust
        {1'b0, 1'b0, 4'b1110, 4'd2, 4'd2, 24'h000001}, // R2 mode off
        {1'b1, 1'b0, 4'b1110, 4'd1, 4'd0, 24'h000101}, // R3 minutes up
        {1'b1, 1'b0, 4'b1001, 4'd1, 4'd0, 24'h000100}, // R3 seconds down
        {1'b1, 1'b1, 4'b1111, 4'd0, 4'd1, 24'h000059}, // R7 borrow reload
        {1'b1, 1'b1, 4'b1110, 4'd2, 4'd0, 24'h000059}  // R12 repeat tick while counting
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1, 2, 8, 12, 13: return "R3";
            3, 4, 5, 6, 9:      return "R5";
            7:                  return "R4";
            10, 15:             return "R12";
            11:                 return "R2";
            default:            return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rep();
        rep_tick = 1'b1;
        @(negedge clk);
        rep_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sec();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", 32'(bcd_time), 32'h0);
        check("R1", 32'(running), 32'd0);
        check("R1", 32'(warn_n), 32'd1);
        check("R1", 32'(done), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [37:0] v;
            v = VEC[i];
            mode_en = v[37];
            run_sw  = v[36];
            key_n   = v[35:32];
            settle();
            for (int r = 0; r < int'(v[31:28]); r++) pulse_rep();
            for (int s = 0; s < int'(v[27:24]); s++) begin
                pulse_sec();
                @(negedge clk);
            end
            check(vec_req(i), 32'(bcd_time), 32'(v[23:0]));
        end
        key_n = 4'hF;

        // R6 counting state, R10 warning idle before final minute tick
        check("R6", 32'(running), 32'd1);
        check("R10", 32'(warn_n), 32'd1);
        pulse_sec();
        check("R6", 32'(bcd_time), 32'h000058);
        check("R10", 32'(warn_n), 32'd0);
        @(negedge clk);
        for (int s = 0; s < 56; s++) begin
            pulse_sec();
            @(negedge clk);
        end
        check("R6", 32'(bcd_time), 32'h000002);
        check("R10", 32'(warn_n), 32'd0);
        pulse_sec();
        check("R10", 32'(warn_n), 32'd1);
        check("R9", 32'(done), 32'd0);
        @(negedge clk);
        pulse_sec();
        check("R9", 32'(done), 32'd1);
        check("R9", 32'(bcd_time), 32'h0);
        check("R8", 32'(running), 32'd0);
        @(negedge clk);
        check("R9", 32'(done), 32'd0);
        check("R10", 32'(warn_n), 32'd1);
        for (int s = 0; s < 3; s++) begin
            pulse_sec();
            check("R8", 32'(done), 32'd0);
            @(negedge clk);
        end
        check("R8", 32'(bcd_time), 32'h0);

        // R11 start with empty count
        run_sw = 1'b0;
        settle();
        run_sw = 1'b1;
        settle();
        check("R11", 32'(running), 32'd0);
        pulse_sec();
        check("R11", 32'(done), 32'd0);
        @(negedge clk);

        // R9 one-second run from adjust
        run_sw = 1'b0;
        key_n = 4'b1010;
        settle();
        pulse_rep();
        key_n = 4'hF;
        run_sw = 1'b1;
        settle();
        check("R6", 32'(running), 32'd1);
        pulse_sec();
        check("R9", 32'(done), 32'd1);
        @(negedge clk);

        // R1 reset mid-use clears the count
        run_sw = 1'b0;
        key_n = 4'b0110;
        settle();
        pulse_rep();
        check("R3", 32'(bcd_time), 32'h010000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        key_n = 4'hF;
        @(negedge clk);
        check("R1", 32'(bcd_time), 32'h0);
        check("R1", 32'(running), 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule